// File: doc/BRIEF.md
# Paged I/O Space Address Decoder

This block turns a 1 KB I/O window in a 16-bit, 6502-style address space into chip selects and strobes. A parameter places the window, which sits at $9000-$93FF by default. The window holds four 256-byte pages, selected by address bits 9:8, and each page is treated differently.

- **Page 0** belongs to a video controller that decodes its own registers, so the decoder stays silent there.
- **Page 1** is cut into eight 32-byte paragraphs:
  - The first two paragraphs merge into one enable for a pair of peripheral-interface chips.
  - The third paragraph is halved into two 16-byte regions, each with its own active-low read and write strobe.
  - The last five paragraphs are reserved 32-byte expansion selects.
- **Pages 2 and 3** merge into a single select for a 512-byte RAM.

The lower strobe pair drives a small 8-bit configuration register held inside the block. The register takes the data bus value when its write strobe ends, and it can be read back on a read-data output. The other strobe pair is brought out for later use. Address-based selects are combinational. Strobes are also qualified by the bus clock phase (phi2) and the read/not-write line.

Top module: `io_page_decoder`

## Requirements
- R1: Every select and strobe output stays inactive when `win_en` is low or when address bits 15:10 differ from `WIN_TAG` (default 6'h24, the window $9000-$93FF). Inactive means `periph_en`=0, all `_n` outputs 1 and `cfg_rdata`=0.
- R2: No output is active for the first page ($9000-$90FF).
- R3: `periph_en` is 1 for the 64 addresses $9100-$913F and 0 elsewhere.
- R4: For $9140-$914F, `cfg_rd_n` is 0 exactly when `phi2`=1 and `rnw`=1, and `cfg_wr_n` is 0 exactly when `phi2`=1 and `rnw`=0.
- R5: `aux_rd_n` and `aux_wr_n` follow the same rule as R4 for $9150-$915F. A write there leaves the configuration register unchanged.
- R6: `rsv_sel_n[i]` is 0 for the 32 addresses starting at $9160 + 32*i (i = 0..4) and 1 elsewhere.
- R7: `ram_sel_n` is 0 for $9200-$93FF and 1 elsewhere.
- R8: No strobe is low while `phi2` is 0.
- R9: For any input combination, at most one of `periph_en`, the four strobes, the five reserved selects and `ram_sel_n` is active.
- R10: A clock edge with `rst_n` low sets `cfg_q` to 8'h00.
- R11: The configuration register loads the `wdata` value sampled at the last clock edge that saw `cfg_wr_n` low. The load happens at the first later edge that sees `cfg_wr_n` high. Nothing else changes `cfg_q`.
- R12: `cfg_rdata` equals `cfg_q` while `cfg_rd_n` is 0 and is 8'h00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the strobes |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 16 | CPU address bus |
| win_en | input | 1 | I/O window enable, active high |
| rnw | input | 1 | 1 = read cycle, 0 = write cycle |
| phi2 | input | 1 | Bus clock phase 2, strobes only while high |
| wdata | input | 8 | CPU write data |
| periph_en | output | 1 | Enable for the two peripheral-interface chips, active high |
| cfg_rd_n | output | 1 | Configuration register read strobe, active low |
| cfg_wr_n | output | 1 | Configuration register write strobe, active low |
| aux_rd_n | output | 1 | Spare read strobe, active low |
| aux_wr_n | output | 1 | Spare write strobe, active low |
| rsv_sel_n | output | 5 | Reserved 32-byte expansion selects, active low |
| ram_sel_n | output | 1 | 512-byte hidden RAM select, active low |
| cfg_q | output | 8 | Current configuration register value |
| cfg_rdata | output | 8 | Configuration readback, zero unless being read |

## Verification
The bench uses the default parameters: a 16-bit address, window tag 6'h24 and an 8-bit register. These make the whole 64K address space small enough to sweep completely. Every address is driven with every combination of `rnw` and `phi2` while the window is enabled, and again with the window disabled. All outputs are compared against a map computed arithmetically from the address fields. Clocked sequences then cover the register's reset, its load timing at the strobe's end, readback gating, and a write to the spare region.

// File: rtl/iodec_pkg.sv
// Shared constants for the paged I/O decoder.
// Assumes a 1 KB window: 2 page bits, 3 paragraph bits, 1 half-paragraph bit.
package iodec_pkg;
    localparam int PAGE_LSB  = 8;
    localparam int PAGE_W    = 2;
    localparam int PAGES     = 1 << PAGE_W;
    localparam int PARA_LSB  = 5;
    localparam int PARA_W    = 3;
    localparam int PARAS     = 1 << PARA_W;
    localparam int HALF_BIT  = 4;
    localparam int WIN_LSB   = PAGE_LSB + PAGE_W;
    localparam int PERIPH_LAST = 1;            // paragraphs 0..1 merged
    localparam int STRB_PARA   = 2;            // paragraph split into strobes
    localparam int RSV_FIRST   = 3;
    localparam int N_RSV       = PARAS - RSV_FIRST;

    typedef struct packed {
        logic rd_n;
        logic wr_n;
    } strobe_t;
endpackage

// File: rtl/iodec_page_split.sv
// Decodes the window hit and splits the window into one-hot pages.
// Assumes the window tag is compared against the address bits above the page field.
module iodec_page_split
    import iodec_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int TAG_W  = ADDR_W - WIN_LSB,
    parameter logic [TAG_W-1:0] WIN_TAG = '0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              win_en,
    output logic [PAGES-1:0]  page_hit
);
    logic win_hit;
    logic [PAGE_W-1:0] page_idx;

    assign win_hit  = win_en && (addr[ADDR_W-1:WIN_LSB] == WIN_TAG);
    assign page_idx = addr[PAGE_LSB +: PAGE_W];

    // One comparator per page, gated by the window hit.
    for (genvar p = 0; p < PAGES; p++) begin : g_page
        assign page_hit[p] = win_hit && (page_idx == PAGE_W'(p));
    end
endmodule

// File: rtl/iodec_para_split.sv
// Splits the peripheral page into one-hot 32-byte paragraphs.
// Assumes page_ok is already one-hot-qualified by the page decoder.
module iodec_para_split
    import iodec_pkg::*;
(
    input  logic              page_ok,
    input  logic [PARA_W-1:0] para_idx,
    output logic [PARAS-1:0]  para_hit
);
    // One comparator per paragraph.
    for (genvar q = 0; q < PARAS; q++) begin : g_para
        assign para_hit[q] = page_ok && (para_idx == PARA_W'(q));
    end
endmodule

// File: rtl/iodec_strobe_pair.sv
// Produces an active-low read/write strobe pair for one 16-byte region.
// Assumes region_hit is purely address-derived; phi2 and rnw qualify it here.
module iodec_strobe_pair (
    input  logic clk,
    input  logic rst_n,
    input  logic region_hit,
    input  logic rnw,
    input  logic phi2,
    output logic rd_n,
    output logic wr_n
);
    // Strobes are active only in phase 2, with direction picked by rnw.
    always_comb begin
        rd_n = !(region_hit && phi2 && rnw);
        wr_n = !(region_hit && phi2 && !rnw);
    end

    // R8
    strobe_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !phi2 |-> (rd_n && wr_n));

    // R4
    strobe_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));
endmodule

// File: rtl/iodec_cfg_reg.sv
// Configuration register: loads on the end of its write strobe, gated readback.
// Assumes the strobes are sampled by clk; data is taken while the strobe is low.
module iodec_cfg_reg #(
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] shadow;
    logic              wr_n_d;

    // Hold write data while the strobe is low, commit on its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= RST_VAL;
            shadow <= RST_VAL;
            wr_n_d <= 1'b1;
        end else begin
            wr_n_d <= wr_n;
            if (!wr_n)
                shadow <= wdata;
            if (wr_n && !wr_n_d)
                q <= shadow;
        end
    end

    // Readback only while the read strobe is active.
    always_comb rdata = rd_n ? '0 : q;

    // R11
    cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && wr_n && !$past(wr_n)) |=> (q == $past(wdata, 2)));

    // R11
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !(wr_n && !$past(wr_n))) |=> $stable(q));

    // R10
    cfg_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (q == RST_VAL));
endmodule

// File: rtl/io_page_decoder.sv
// Top of the paged I/O decoder: page, paragraph and half-paragraph decode,
// merged peripheral and RAM selects, and the configuration register.
// Assumes a 1 KB window whose location is set by WIN_TAG.
module io_page_decoder
    import iodec_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-WIN_LSB-1:0] WIN_TAG = 6'h24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              win_en,
    input  logic              rnw,
    input  logic              phi2,
    input  logic [DATA_W-1:0] wdata,
    output logic              periph_en,
    output logic              cfg_rd_n,
    output logic              cfg_wr_n,
    output logic              aux_rd_n,
    output logic              aux_wr_n,
    output logic [N_RSV-1:0]  rsv_sel_n,
    output logic              ram_sel_n,
    output logic [DATA_W-1:0] cfg_q,
    output logic [DATA_W-1:0] cfg_rdata
);
    localparam int TAG_W = ADDR_W - WIN_LSB;

    logic [PAGES-1:0] page_hit;
    logic [PARAS-1:0] para_hit;
    logic [1:0]       half_hit;
    strobe_t          strb [2];

    iodec_page_split #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .WIN_TAG(WIN_TAG)) u_page (
        .addr     (addr),
        .win_en   (win_en),
        .page_hit (page_hit)
    );

    iodec_para_split u_para (
        .page_ok  (page_hit[1]),
        .para_idx (addr[PARA_LSB +: PARA_W]),
        .para_hit (para_hit)
    );

    // Split the strobe paragraph on the half bit.
    always_comb begin
        half_hit[0] = para_hit[STRB_PARA] && !addr[HALF_BIT];
        half_hit[1] = para_hit[STRB_PARA] &&  addr[HALF_BIT];
    end

    for (genvar h = 0; h < 2; h++) begin : g_strb
        iodec_strobe_pair u_sp (
            .clk        (clk),
            .rst_n      (rst_n),
            .region_hit (half_hit[h]),
            .rnw        (rnw),
            .phi2       (phi2),
            .rd_n       (strb[h].rd_n),
            .wr_n       (strb[h].wr_n)
        );
    end

    // Reserved paragraphs, one active-low select each.
    for (genvar r = 0; r < N_RSV; r++) begin : g_rsv
        assign rsv_sel_n[r] = !para_hit[RSV_FIRST + r];
    end

    // Merged selects and strobe routing.
    always_comb begin
        periph_en = |para_hit[PERIPH_LAST:0];
        ram_sel_n = !(page_hit[2] || page_hit[3]);
        cfg_rd_n  = strb[0].rd_n;
        cfg_wr_n  = strb[0].wr_n;
        aux_rd_n  = strb[1].rd_n;
        aux_wr_n  = strb[1].wr_n;
    end

    iodec_cfg_reg #(.DATA_W(DATA_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_n  (cfg_wr_n),
        .rd_n  (cfg_rd_n),
        .wdata (wdata),
        .q     (cfg_q),
        .rdata (cfg_rdata)
    );

    // R9
    single_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({periph_en, ~cfg_rd_n, ~cfg_wr_n, ~aux_rd_n, ~aux_wr_n,
                    ~rsv_sel_n, ~ram_sel_n}) <= 1);

    // R1
    idle_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_en || addr[ADDR_W-1:WIN_LSB] != WIN_TAG) |->
        (!periph_en && cfg_rd_n && cfg_wr_n && aux_rd_n && aux_wr_n &&
         (&rsv_sel_n) && ram_sel_n && cfg_rdata == '0));

    // R7
    ram_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_sel_n |-> addr[PAGE_LSB + 1]);

    // R2
    video_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[PAGE_LSB +: PAGE_W] == '0) |->
        (!periph_en && cfg_rd_n && cfg_wr_n && aux_rd_n && aux_wr_n &&
         (&rsv_sel_n) && ram_sel_n));
endmodule

// File: tb/test_io_page_decoder.sv
// Bench: full address sweep against an arithmetic map, plus register sequences.
module test_io_page_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic        win_en = 1'b0;
    logic        rnw = 1'b1;
    logic        phi2 = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic        periph_en, cfg_rd_n, cfg_wr_n, aux_rd_n, aux_wr_n, ram_sel_n;
    logic [4:0]  rsv_sel_n;
    logic [7:0]  cfg_q, cfg_rdata;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    io_page_decoder i_io_page_decoder (
        .clk(clk), .rst_n(rst_n), .addr(addr), .win_en(win_en), .rnw(rnw),
        .phi2(phi2), .wdata(wdata), .periph_en(periph_en), .cfg_rd_n(cfg_rd_n),
        .cfg_wr_n(cfg_wr_n), .aux_rd_n(aux_rd_n), .aux_wr_n(aux_wr_n),
        .rsv_sel_n(rsv_sel_n), .ram_sel_n(ram_sel_n), .cfg_q(cfg_q),
        .cfg_rdata(cfg_rdata)
    );

    // Expected outputs: {periph, cfg_rd_n, cfg_wr_n, aux_rd_n, aux_wr_n, rsv_n[4:0], ram_n, rdata}
    function automatic logic [18:0] model(input logic [15:0] a, input logic en,
                                          input logic r, input logic p, input logic [7:0] cv);
        logic per = 1'b0, crd = 1'b1, cwr = 1'b1, ard = 1'b1, awr = 1'b1, ram = 1'b1;
        logic [4:0] rsv = 5'h1F;
        logic [7:0] rd = 8'h00;
        int page = int'(a[9:8]);
        int para = int'(a[7:5]);
        if (en && a[15:10] == 6'h24) begin
            if (page == 1) begin
                if (para < 2) per = 1'b1;
                else if (para == 2) begin
                    if (!a[4]) begin crd = !(p && r); cwr = !(p && !r); end
                    else       begin ard = !(p && r); awr = !(p && !r); end
                end else rsv[para - 3] = 1'b0;
            end else if (page >= 2) ram = 1'b0;
        end
        if (!crd) rd = cv;
        return {per, crd, cwr, ard, awr, rsv, ram, rd};
    endfunction

    function automatic string req_of(input logic [15:0] a, input logic en);
        if (!en || a[15:10] != 6'h24) return "R1";
        if (a[9:8] == 2'd0) return "R2";
        if (a[9]) return "R7";
        if (a[7:6] == 2'd0) return "R3";
        if (a[7:5] == 3'd2) return a[4] ? "R5/R8/R9" : "R4/R8/R9/R12";
        return "R6";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [18:0] outs();
        return {periph_en, cfg_rd_n, cfg_wr_n, aux_rd_n, aux_wr_n, rsv_sel_n, ram_sel_n, cfg_rdata};
    endfunction

    // One clocked write to the strobe paragraph: strobe low for a cycle, then released.
    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; win_en = 1'b1; rnw = 1'b0; phi2 = 1'b1; wdata = d;
        @(negedge clk); phi2 = 1'b0; wdata = ~d;
        @(negedge clk); rnw = 1'b1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10", 32'(cfg_q), 32'h00);
        rst_n = 1'b1;

        // R12: read of the reset value, then gated off in phase 1.
        @(negedge clk); addr = 16'h9140; win_en = 1'b1; rnw = 1'b1; phi2 = 1'b1; #1;
        check("R12", 32'(cfg_rdata), 32'h00);

        // R11: load takes the data held while the strobe was low, not the later bus value.
        bus_write(16'h9147, 8'hA5);
        check("R11", 32'(cfg_q), 32'hA5);
        phi2 = 1'b1; #1;
        check("R12", 32'(cfg_rdata), 32'hA5);
        phi2 = 1'b0; #1;
        check("R12", 32'(cfg_rdata), 32'h00);

        // R11: strobe held low several cycles keeps cfg_q until release.
        @(negedge clk); addr = 16'h914F; rnw = 1'b0; phi2 = 1'b1; wdata = 8'h11;
        @(negedge clk); wdata = 8'h22;
        @(negedge clk);
        check("R11", 32'(cfg_q), 32'hA5);
        phi2 = 1'b0; wdata = 8'h99;
        @(negedge clk);
        check("R11", 32'(cfg_q), 32'h22);

        // R5: spare-region write leaves the register alone.
        bus_write(16'h9150, 8'h77);
        check("R5", 32'(cfg_q), 32'h22);

        bus_write(16'h9140, 8'h3C);
        check("R11", 32'(cfg_q), 32'h3C);

        // Full sweep, window enabled, all rnw/phi2 combinations.
        wdata = 8'h3C;
        for (int a = 0; a < 65536; a++) begin
            for (int c = 0; c < 4; c++) begin
                addr = 16'(a); win_en = 1'b1; rnw = c[0]; phi2 = c[1];
                #1;
                check(req_of(addr, 1'b1), 32'(outs()), 32'(model(addr, 1'b1, rnw, phi2, 8'h3C)));
            end
        end
        // Full sweep, window disabled.
        for (int a = 0; a < 65536; a++) begin
            for (int c = 0; c < 2; c++) begin
                addr = 16'(a); win_en = 1'b0; rnw = c[0]; phi2 = 1'b1;
                #1;
                check("R1", 32'(outs()), 32'(model(addr, 1'b0, rnw, phi2, 8'h3C)));
            end
        end

        // R10: synchronous reset clears the register.
        @(negedge clk); win_en = 1'b0; phi2 = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        check("R10", 32'(cfg_q), 32'h00);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule